// File: doc/BRIEF.md
# Oversampling Serial Receiver with Ninth-Bit Address Filter

This block receives asynchronous serial frames on a single input line, for point-to-point RS-232 links or shared RS-485 buses. It builds a 16x sampling tick from the core clock through a coarse prescaler and a programmable divisor. It finds the falling edge of a start bit and takes each bit as a three-sample majority near the bit centre. It assembles frames of 8 or 9 data bits, least significant bit first. Finished frames go into a two-entry queue, and software pops them through a read strobe.

On a shared bus, a node can be set to listen only for address frames. These are 9-bit frames with the top bit set. All other frames vanish without a trace. Once the node sees its own address, software turns the filter off and takes the data that follows. The overrun and framing indications are sticky. They clear only when the receive enable is dropped. An overrun also stops reception until that happens.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `avail_o`, `ovr_err_o`, `frm_err_o` and `irq_o` are 0.
- R2: With `nine_bit_i`=0, a frame is a low start bit, 8 data bits least significant bit first, and a stop bit. The byte appears on `rd_data_o` and `rd_bit9_o` reads 0.
- R3: With `nine_bit_i`=1, nine data bits are received. The last one appears on `rd_bit9_o` next to the low byte.
- R4: The bit period is 16·P·(D+1) clocks. P is 64, 16 or 4 for `presc_sel_i` = 00, 01 or 1x. D is {`div_hi_i`,`div_lo_i`} when `div_wide_i`=1, and `div_lo_i` alone (high byte ignored) when it is 0.
- R5: With `nine_bit_i`=1 and `addr_filt_i`=1, a frame whose ninth bit is 0 is dropped and sets no flag. A frame whose ninth bit is 1 is stored. With the filter off, or in 8-bit mode, every frame is stored.
- R6: The queue holds two frames in arrival order. `avail_o` is 1 while it is non-empty, and the head stays on the read outputs until `rd_i` pops it.
- R7: A frame that completes while the queue is full, with no pop in that cycle, sets `ovr_err_o` and is dropped. Reception then stops until the error is cleared, and the stored frames stay readable.
- R8: Driving `rx_en_i` low clears `ovr_err_o` and `frm_err_o` on the next clock. Reception resumes once it is high again.
- R9: A stored frame whose stop bit is sampled low sets `frm_err_o`. The frame is still stored.
- R10: `irq_o` is 1 exactly when `avail_o` and `irq_en_i` are both 1.
- R11: A low pulse on the line that has ended before the middle of a bit period is rejected as a start bit, and no frame results.
- R12: While `port_en_i` or `rx_en_i` is 0, no frame is received.
- R13: A frame completing into a full queue in the same cycle that `rd_i` pops the head is stored without an overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Serial line, idle high |
| port_en_i | input | 1 | Serial port enable |
| rx_en_i | input | 1 | Receive enable; low clears errors |
| nine_bit_i | input | 1 | 1 = nine data bits per frame |
| addr_filt_i | input | 1 | Keep only frames with ninth bit set (9-bit mode) |
| div_wide_i | input | 1 | 1 = 16-bit divisor, 0 = low byte only |
| presc_sel_i | input | 2 | Prescale: 00 /64, 01 /16, 1x /4 |
| div_hi_i | input | 8 | Divisor high byte |
| div_lo_i | input | 8 | Divisor low byte |
| irq_en_i | input | 1 | Interrupt enable |
| rd_i | input | 1 | Pop the head frame |
| rd_data_o | output | 8 | Head frame, low eight bits |
| rd_bit9_o | output | 1 | Head frame, ninth bit |
| avail_o | output | 1 | Queue non-empty |
| ovr_err_o | output | 1 | Sticky overrun |
| frm_err_o | output | 1 | Sticky framing error |
| irq_o | output | 1 | Level interrupt |

## Verification
The delicate coincidence is a frame landing in a full queue in the same clock that software pops the head. This is the boundary between a clean store and an overrun. The bench first measures the delay from a start edge to `avail_o` rising on an empty queue. It fills the queue with two frames, then launches a third frame on the same tick phase and pulses `rd_i` exactly in the cycle the push lands. It expects the popped head to be the first frame, no overrun, and the second and third frames read back in order. The same fill without a read must raise the overrun, drop the frame and block the next one.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/uart_rx_baud.sv
module uart_rx_baud #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        presc_sel_i,
  input  logic              wide_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  output logic              tick_o
);
  localparam int DIV_W = 2 * BYTE_W;
  localparam int PRE_W = 6;

  logic [PRE_W-1:0] pre_cnt, pre_nxt, pre_lim;
  logic [DIV_W-1:0] div_cnt, div_nxt, div_val;
  logic             pre_wrap, div_wrap;

  always_comb begin
    unique case (presc_sel_i)
      2'b00:   pre_lim = PRE_W'(63);
      2'b01:   pre_lim = PRE_W'(15);
      default: pre_lim = PRE_W'(3);
    endcase
    div_val  = wide_i ? {div_hi_i, div_lo_i} : {{BYTE_W{1'b0}}, div_lo_i};
    pre_wrap = (pre_cnt >= pre_lim);
    pre_nxt  = pre_wrap ? '0 : pre_cnt + 1'b1;
    div_wrap = pre_wrap && (div_cnt >= div_val);
    div_nxt  = div_cnt;
    if (pre_wrap) div_nxt = div_wrap ? '0 : div_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      div_cnt <= '0;
    end else begin
      pre_cnt <= pre_nxt;
      div_cnt <= div_nxt;
    end
  end

  assign tick_o = div_wrap;
endmodule

// File: rtl/uart_rx_core.sv
module uart_rx_core
  import uart_rx_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int OVS    = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            rx_i,
  input  logic            nine_i,
  output logic            done_o,
  output logic [BYTE_W:0] frame_o,
  output logic            stop_ok_o
);
  localparam int FW  = BYTE_W + 1;
  localparam int CW  = $clog2(OVS);
  localparam int IW  = $clog2(FW);
  localparam int MID = OVS / 2;
  localparam logic [CW-1:0] POS_A = CW'(MID - 1);
  localparam logic [CW-1:0] POS_B = CW'(MID);
  localparam logic [CW-1:0] POS_C = CW'(MID + 1);
  localparam logic [CW-1:0] POS_L = CW'(OVS - 1);

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [IW-1:0] idx_q, idx_n, idx_last;
  logic          sa_q, sa_n, sb_q, sb_n, vote;
  logic [FW-1:0] fr_q, fr_n;
  logic          done_q, done_n, ok_q, ok_n;

  assign rx_s     = sync_q[1];
  assign vote     = maj3(sa_q, sb_q, rx_s);
  assign idx_last = nine_i ? IW'(BYTE_W) : IW'(BYTE_W - 1);

  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    idx_n  = idx_q;
    sa_n   = sa_q;
    sb_n   = sb_q;
    fr_n   = fr_q;
    done_n = 1'b0;
    ok_n   = ok_q;
    if (!en_i) begin
      st_n = RX_IDLE;
    end else if (tick_i) begin
      if (st_q == RX_IDLE) begin
        if (!rx_s) begin
          st_n  = RX_START;
          cnt_n = CW'(1);
          fr_n  = '0;
        end
      end else begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == POS_A) sa_n = rx_s;
        if (cnt_q == POS_B) sb_n = rx_s;
        if (cnt_q == POS_C) begin
          unique case (st_q)
            RX_START: if (vote) st_n = RX_IDLE;
            RX_DATA:  fr_n[idx_q] = vote;
            RX_STOP: begin
              done_n = 1'b1;
              ok_n   = vote;
              st_n   = RX_IDLE;
            end
            default: ;
          endcase
        end
        if (cnt_q == POS_L) begin
          if (st_q == RX_START) begin
            st_n  = RX_DATA;
            idx_n = '0;
          end else if (st_q == RX_DATA) begin
            if (idx_q == idx_last) st_n = RX_STOP;
            else                   idx_n = idx_q + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      sa_q   <= 1'b1;
      sb_q   <= 1'b1;
      fr_q   <= '0;
      done_q <= 1'b0;
      ok_q   <= 1'b1;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      idx_q  <= idx_n;
      sa_q   <= sa_n;
      sb_q   <= sb_n;
      fr_q   <= fr_n;
      done_q <= done_n;
      ok_q   <= ok_n;
    end
  end

  assign done_o    = done_q;
  assign frame_o   = fr_q;
  assign stop_ok_o = ok_q;
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] rdata_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_n, rd_q, rd_n;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    wr_n = wr_q;
    rd_n = rd_q;
    if (push_i) wr_n = (wr_q == LAST) ? '0 : wr_q + 1'b1;
    if (pop_i)  rd_n = (rd_q == LAST) ? '0 : rd_q + 1'b1;
    unique case ({push_i, pop_i})
      2'b10:   cnt_n = cnt_q + 1'b1;
      2'b01:   cnt_n = cnt_q - 1'b1;
      default: cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_n;
      rd_q  <= rd_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_q] <= wdata_i;
  end

  assign rdata_o = mem[rd_q];
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULLC);
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 2,
  parameter int OVS        = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              port_en_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              addr_filt_i,
  input  logic              div_wide_i,
  input  logic [1:0]        presc_sel_i,
  input  logic [BYTE_W-1:0] div_hi_i,
  input  logic [BYTE_W-1:0] div_lo_i,
  input  logic              irq_en_i,
  input  logic              rd_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              rd_bit9_o,
  output logic              avail_o,
  output logic              ovr_err_o,
  output logic              frm_err_o,
  output logic              irq_o
);
  localparam int FW = BYTE_W + 1;

  logic          tick, core_en, done, stop_ok;
  logic [FW-1:0] frame, head;
  logic          empty, full, pop, push, pass, take, ovr_set;
  logic          ovr_q, ovr_n, frm_q, frm_n;

  uart_rx_baud #(.BYTE_W(BYTE_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .presc_sel_i(presc_sel_i), .wide_i(div_wide_i),
    .div_hi_i(div_hi_i), .div_lo_i(div_lo_i), .tick_o(tick)
  );

  uart_rx_core #(.BYTE_W(BYTE_W), .OVS(OVS)) u_core (
    .clk(clk), .rst_n(rst_n), .en_i(core_en), .tick_i(tick), .rx_i(rx_i),
    .nine_i(nine_bit_i), .done_o(done), .frame_o(frame), .stop_ok_o(stop_ok)
  );

  uart_rx_fifo #(.W(FW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .wdata_i(frame),
    .rdata_o(head), .empty_o(empty), .full_o(full)
  );

  always_comb begin
    core_en = port_en_i && rx_en_i && !ovr_q;
    pop     = rd_i && !empty;
    pass    = !(nine_bit_i && addr_filt_i) || frame[BYTE_W];
    take    = done && pass;
    push    = take && (!full || pop);
    ovr_set = take && full && !pop;
    ovr_n   = ovr_q;
    frm_n   = frm_q;
    if (!rx_en_i) begin
      ovr_n = 1'b0;
      frm_n = 1'b0;
    end else begin
      if (ovr_set)           ovr_n = 1'b1;
      if (push && !stop_ok)  frm_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q <= 1'b0;
      frm_q <= 1'b0;
    end else begin
      ovr_q <= ovr_n;
      frm_q <= frm_n;
    end
  end

  assign rd_data_o = empty ? '0 : head[BYTE_W-1:0];
  assign rd_bit9_o = !empty && head[BYTE_W];
  assign avail_o   = !empty;
  assign ovr_err_o = ovr_q;
  assign frm_err_o = frm_q;
  assign irq_o     = !empty && irq_en_i;
endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_en_i,
  input logic       rx_en_i,
  input logic       rd_i,
  input logic [7:0] rd_data_o,
  input logic       rd_bit9_o,
  input logic       avail_o,
  input logic       ovr_err_o,
  input logic       frm_err_o,
  input logic       irq_o
);
  // R10
  irq_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> avail_o);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> (!ovr_err_o && !frm_err_o));

  // R7
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en_i && ovr_err_o) |=> ovr_err_o);

  // R7
  ovr_when_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_err_o) |-> avail_o);

  // R6
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (avail_o && !rd_i) |=> (avail_o && $stable(rd_data_o) && $stable(rd_bit9_o)));

  // R12
  no_rx_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_en_i && !$past(port_en_i) && !$past(port_en_i, 2)) |-> !$rose(avail_o));
endmodule

bind uart_addr_rx uart_addr_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_en_i(port_en_i), .rx_en_i(rx_en_i), .rd_i(rd_i),
  .rd_data_o(rd_data_o), .rd_bit9_o(rd_bit9_o), .avail_o(avail_o),
  .ovr_err_o(ovr_err_o), .frm_err_o(frm_err_o), .irq_o(irq_o)
);

// File: tb/uart_addr_rx_test.sv
module uart_addr_rx_test;
  logic       clk = 1'b0;
  logic       rst_n, rx_i, port_en_i, rx_en_i, nine_bit_i, addr_filt_i, div_wide_i;
  logic [1:0] presc_sel_i;
  logic [7:0] div_hi_i, div_lo_i, rd_data_o;
  logic       irq_en_i, rd_i, rd_bit9_o, avail_o, ovr_err_o, frm_err_o, irq_o;

  always #4 clk = ~clk;

  uart_addr_rx uut (.*);

  int         cyc = 0;
  int         checks = 0, errors = 0;
  int         bitlen = 64;
  int         pulse_at = -1;
  logic [8:0] pulse_exp;
  logic [8:0] exp_q[$];
  logic [8:0] e;
  logic       mon_on = 1'b0;
  string      req = "R2";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  // monitor: pops the queue model and compares each frame read from the design
  always @(negedge clk) begin
    rd_i = 1'b0;
    if (pulse_at == cyc) begin
      chk({rd_bit9_o, rd_data_o} == pulse_exp, "R13", "head at coincident read",
          {rd_bit9_o, rd_data_o}, pulse_exp);
      rd_i = 1'b1;
    end else if (mon_on && avail_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, req, "unexpected frame", {rd_bit9_o, rd_data_o}, 0);
      end else begin
        e = exp_q.pop_front();
        chk({rd_bit9_o, rd_data_o} == e, req, "frame", {rd_bit9_o, rd_data_o}, e);
      end
      rd_i = 1'b1;
    end
  end

  // driver: called on a negedge, returns on a negedge
  task automatic send(input logic [8:0] v, input bit nine, input bit stop_hi);
    rx_i = 1'b0;
    repeat (bitlen) @(negedge clk);
    for (int i = 0; i < (nine ? 9 : 8); i++) begin
      rx_i = v[i];
      repeat (bitlen) @(negedge clk);
    end
    rx_i = stop_hi;
    repeat (bitlen) @(negedge clk);
    rx_i = 1'b1;
    repeat (bitlen) @(negedge clk);
  endtask

  task automatic drain();
    int t = 0;
    while (exp_q.size() != 0 && t < 4000) begin
      @(negedge clk);
      t++;
    end
    chk(exp_q.size() == 0, req, "frames still pending", exp_q.size(), 0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finish_run();
  end

  initial begin
    int c1, c0, lat;
    rst_n = 1'b0; rx_i = 1'b1; port_en_i = 1'b1; rx_en_i = 1'b1;
    nine_bit_i = 1'b0; addr_filt_i = 1'b0; div_wide_i = 1'b0;
    presc_sel_i = 2'b10; div_hi_i = 8'h00; div_lo_i = 8'h00; irq_en_i = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!avail_o && !ovr_err_o && !frm_err_o && !irq_o, "R1", "reset outputs",
        {avail_o, ovr_err_o, frm_err_o, irq_o}, 0);
    idle(32);

    // R2: 8-bit frames
    req = "R2"; mon_on = 1'b1;
    exp_q.push_back(9'h0A5); send(9'h1A5, 1'b0, 1'b1);
    exp_q.push_back(9'h03C); send(9'h03C, 1'b0, 1'b1);
    drain();

    // R3: 9-bit frames, filter off
    req = "R3"; nine_bit_i = 1'b1;
    exp_q.push_back(9'h15A); send(9'h15A, 1'b1, 1'b1);
    exp_q.push_back(9'h0C3); send(9'h0C3, 1'b1, 1'b1);
    drain();

    // R5: address filter
    req = "R5"; addr_filt_i = 1'b1;
    send(9'h011, 1'b1, 1'b1);
    idle(bitlen);
    chk(!avail_o && !frm_err_o && !ovr_err_o, "R5", "filtered frame left flags",
        {avail_o, frm_err_o, ovr_err_o}, 0);
    exp_q.push_back(9'h122); send(9'h122, 1'b1, 1'b1);
    drain();
    addr_filt_i = 1'b0;
    exp_q.push_back(9'h033); send(9'h033, 1'b1, 1'b1);
    drain();
    nine_bit_i = 1'b0; addr_filt_i = 1'b1;
    exp_q.push_back(9'h044); send(9'h044, 1'b0, 1'b1);
    drain();
    addr_filt_i = 1'b0;

    // R10: interrupt level
    req = "R10"; mon_on = 1'b0;
    send(9'h055, 1'b0, 1'b1);
    chk(irq_o && avail_o, "R10", "irq with data and enable", {irq_o, avail_o}, 3);
    irq_en_i = 1'b0; @(negedge clk);
    chk(!irq_o, "R10", "irq masked", irq_o, 0);
    irq_en_i = 1'b1;
    exp_q.push_back(9'h055); mon_on = 1'b1;
    drain();
    @(negedge clk);
    chk(!irq_o, "R10", "irq after drain", irq_o, 0);

    // R9: framing error, frame kept; R8 clears it
    req = "R9";
    exp_q.push_back(9'h077); send(9'h077, 1'b0, 1'b0);
    drain();
    idle(2 * bitlen);
    chk(frm_err_o, "R9", "framing flag", frm_err_o, 1);
    rx_en_i = 1'b0; @(negedge clk); @(negedge clk);
    chk(!frm_err_o, "R8", "framing flag cleared", frm_err_o, 0);
    rx_en_i = 1'b1; idle(8);

    // R11: short low glitch
    req = "R11";
    rx_i = 1'b0; idle(bitlen / 4); rx_i = 1'b1;
    idle(3 * bitlen);
    chk(!avail_o && !frm_err_o, "R11", "glitch produced frame", {avail_o, frm_err_o}, 0);

    // R12: port disabled
    req = "R12"; port_en_i = 1'b0;
    send(9'h0E1, 1'b0, 1'b1);
    chk(!avail_o, "R12", "frame while port off", avail_o, 0);
    port_en_i = 1'b1; rx_en_i = 1'b0;
    send(9'h0E2, 1'b0, 1'b1);
    chk(!avail_o, "R12", "frame while receive off", avail_o, 0);
    rx_en_i = 1'b1; idle(8);

    // R13 / R6: push and pop in the same cycle
    req = "R6"; mon_on = 1'b0;
    c1 = cyc; lat = 0;
    fork
      send(9'h0A1, 1'b0, 1'b1);
      begin
        while (!avail_o) @(negedge clk);
        lat = cyc - c1;
      end
    join
    send(9'h0B2, 1'b0, 1'b1);
    chk(avail_o && !ovr_err_o, "R6", "two frames held", {avail_o, ovr_err_o}, 2);
    while (((cyc - c1) % 64) != 0) @(negedge clk);
    c0 = cyc;
    pulse_exp = 9'h0A1;
    pulse_at = c0 + lat - 1;
    send(9'h0C3, 1'b0, 1'b1);
    pulse_at = -1;
    chk(!ovr_err_o, "R13", "overrun on coincident read", ovr_err_o, 0);
    req = "R13";
    exp_q.push_back(9'h0B2); exp_q.push_back(9'h0C3); mon_on = 1'b1;
    drain();

    // R7: overrun
    req = "R7"; mon_on = 1'b0;
    send(9'h0D4, 1'b0, 1'b1);
    send(9'h0E5, 1'b0, 1'b1);
    send(9'h0F6, 1'b0, 1'b1);
    chk(ovr_err_o && avail_o, "R7", "overrun flag", {ovr_err_o, avail_o}, 3);
    send(9'h017, 1'b0, 1'b1);
    exp_q.push_back(9'h0D4); exp_q.push_back(9'h0E5); mon_on = 1'b1;
    drain();
    idle(4);
    chk(!avail_o && ovr_err_o, "R7", "blocked and sticky", {avail_o, ovr_err_o}, 1);
    rx_en_i = 1'b0; @(negedge clk); @(negedge clk);
    chk(!ovr_err_o, "R8", "overrun cleared", ovr_err_o, 0);
    rx_en_i = 1'b1; idle(8);
    req = "R8";
    exp_q.push_back(9'h028); send(9'h028, 1'b0, 1'b1);
    drain();

    // R4: divisor and prescale
    req = "R4";
    presc_sel_i = 2'b01; div_wide_i = 1'b1; div_hi_i = 8'h00; div_lo_i = 8'h01;
    bitlen = 16 * 16 * 2; idle(64);
    exp_q.push_back(9'h096); send(9'h096, 1'b0, 1'b1);
    drain();
    presc_sel_i = 2'b10; div_wide_i = 1'b0; div_hi_i = 8'h05; div_lo_i = 8'h01;
    bitlen = 16 * 4 * 2; idle(64);
    exp_q.push_back(9'h069); send(9'h069, 1'b0, 1'b1);
    drain();

    idle(16);
    finish_run();
  end
endmodule